// File: doc/BRIEF.md
# I2C Mode Control Register

This block is the CPU-facing control register of an I2C interface. It holds the interface enable, the interrupt enable, the master/slave select and the transmit/receive select, plus four general-purpose bits. Software writes it through a simple write port. The current contents are always visible on the read-data output. Alongside software, bus events from the shift engine update the two mode bits directly. An arbitration loss in master mode drops the interface back to slave receive. The read/write bit of the first frame after a START sets the direction of a slave that is receiving.

A direction change written by software while a byte is on the wire does not take effect at once. It is parked as a pending value and applied on the rising SCL edge of the ninth clock, so the direction never flips in the middle of a byte. The enable bit also selects which register bank a shared address slot reaches. The interrupt enable gates the interface's interrupt request to the CPU.

Top module: `i2c_modectl`

## Requirements
- R1: After a synchronous reset, `rd_data` is 0x00, `mode` is 00, `irq_out` is 0 and `bank_sel` is 0.
- R2: A write with `wr_en` high stores bit 7 (enable), bit 6 (interrupt enable), bit 5 (master) and bits 3..0 on the next clock edge. When `xfer_busy` is low, it also stores bit 4 (transmit) on that edge. `rd_data` shows all eight stored bits.
- R3: `mode` is {bit 5, bit 4}: 00 slave receive, 01 slave transmit, 10 master receive, 11 master transmit.
- R4: With the enable bit at 1 and the master bit at 1, an `arb_lost` pulse clears bits 5 and 4 on the next edge. It cancels any pending transmit-bit write, and it beats a write to bits 5..4 in the same cycle. Bits 7, 6 and 3..0 of such a write are still stored.
- R5: With the enable bit at 1 and `mode` at 00, a `first_frame` pulse loads `rw_bit` into bit 4 on the next edge (1 = transmit), and it beats a same-cycle write to bits 5..4.
- R6: A write made while `xfer_busy` is high leaves bit 4 unchanged. Its bit-4 value is held as pending and loaded into bit 4 on the edge that samples `ninth_rise` high.
- R7: A pending transmit-bit write is dropped when the enable bit is 0 or is being written to 0. A later `ninth_rise` then leaves bit 4 alone.
- R8: `irq_out` equals `irq_in` AND the interrupt-enable bit, both sampled one clock earlier.
- R9: `bank_sel` equals the enable bit: 1 selects the mode and data registers, 0 selects the slave-address registers.
- R10: While the enable bit is 0, `arb_lost` and `first_frame` have no effect on bits 5..4.
- R11: A `first_frame` pulse while `mode` is not 00 leaves bits 5..4 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| xfer_busy | input | 1 | A byte transfer is in progress |
| ninth_rise | input | 1 | Pulse on the rising SCL edge of the ninth clock |
| arb_lost | input | 1 | Arbitration-lost pulse |
| first_frame | input | 1 | Pulse when the first frame after START has been received |
| rw_bit | input | 1 | R/W bit of that first frame |
| irq_in | input | 1 | Interrupt request from the interface |
| rd_data | output | 8 | Current register contents |
| mode | output | 2 | {master, transmit} |
| irq_out | output | 1 | Gated interrupt request to the CPU |
| bank_sel | output | 1 | Register-bank select for the shared address slot |

## Verification
The bench first parks a transmit-bit write as pending and then loses arbitration. A design that forgot to cancel the pending value would flip bit 4 to 1 at the following ninth clock. It collides hardware events with CPU writes in the same cycle. A design with the wrong priority would show the written mode bits instead of the hardware result. It then clears the enable bit with a write made during a busy transfer. A design that kept the pending value would change direction at the next ninth edge while disabled. Events arriving while disabled or outside slave receive are checked to leave the mode untouched. The interrupt gate is checked across a change of the interrupt-enable bit, which exposes an off-by-one in its latency.

// File: rtl/i2c_modectl_pkg.sv
package i2c_modectl_pkg;
  localparam int REG_W  = 8;
  localparam int EN_BIT = REG_W - 1;
  localparam int IE_BIT = REG_W - 2;
  localparam int MS_BIT = REG_W - 3;
  localparam int TX_BIT = REG_W - 4;
  localparam int LOW_W  = REG_W - 4;

  typedef enum logic [1:0] {
    MODE_SLV_RX = 2'b00,
    MODE_SLV_TX = 2'b01,
    MODE_MST_RX = 2'b10,
    MODE_MST_TX = 2'b11
  } bus_mode_e;
endpackage

// File: rtl/i2c_modectl_cfg.sv
module i2c_modectl_cfg
  import i2c_modectl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             irq_in,
  output logic             en_q,
  output logic             ie_q,
  output logic [LOW_W-1:0] low_q,
  output logic             irq_out,
  output logic             bank_sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      ie_q     <= 1'b0;
      low_q    <= '0;
      irq_out  <= 1'b0;
      bank_sel <= 1'b0;
    end else begin
      irq_out <= irq_in & ie_q;
      if (wr_en) begin
        en_q     <= wr_data[EN_BIT];
        ie_q     <= wr_data[IE_BIT];
        low_q    <= wr_data[LOW_W-1:0];
        bank_sel <= wr_data[EN_BIT];
      end
    end
  end
endmodule

// File: rtl/i2c_modectl_dir.sv
module i2c_modectl_dir
  import i2c_modectl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_q,
  input  logic wr_en,
  input  logic wr_en_bit,
  input  logic wr_ms,
  input  logic wr_tx,
  input  logic xfer_busy,
  input  logic ninth_rise,
  input  logic arb_lost,
  input  logic first_frame,
  input  logic rw_bit,
  output logic ms_q,
  output logic tx_q
);
  logic pend_q, pval_q;
  logic ms_n, tx_n, pend_n, pval_n;
  logic hw_arb, hw_ff;

  assign hw_arb = en_q & arb_lost & ms_q;
  assign hw_ff  = en_q & first_frame & ~hw_arb &
                  (bus_mode_e'({ms_q, tx_q}) == MODE_SLV_RX);

  always_comb begin
    ms_n   = ms_q;
    tx_n   = tx_q;
    pend_n = pend_q;
    pval_n = pval_q;
    if (hw_arb) begin
      ms_n   = 1'b0;
      tx_n   = 1'b0;
      pend_n = 1'b0;
    end else if (hw_ff) begin
      tx_n = rw_bit;
    end else begin
      if (ninth_rise && pend_q) begin
        tx_n   = pval_q;
        pend_n = 1'b0;
      end
      if (wr_en) begin
        ms_n = wr_ms;
        if (xfer_busy) begin
          pend_n = 1'b1;
          pval_n = wr_tx;
        end else begin
          tx_n   = wr_tx;
          pend_n = 1'b0;
        end
      end
    end
    if (!en_q || (wr_en && !wr_en_bit)) pend_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ms_q   <= 1'b0;
      tx_q   <= 1'b0;
      pend_q <= 1'b0;
      pval_q <= 1'b0;
    end else begin
      ms_q   <= ms_n;
      tx_q   <= tx_n;
      pend_q <= pend_n;
      pval_q <= pval_n;
    end
  end
endmodule

// File: rtl/i2c_modectl.sv
module i2c_modectl
  import i2c_modectl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             xfer_busy,
  input  logic             ninth_rise,
  input  logic             arb_lost,
  input  logic             first_frame,
  input  logic             rw_bit,
  input  logic             irq_in,
  output logic [REG_W-1:0] rd_data,
  output logic [1:0]       mode,
  output logic             irq_out,
  output logic             bank_sel
);
  logic             en_q, ie_q, ms_q, tx_q;
  logic [LOW_W-1:0] low_q;

  i2c_modectl_cfg u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .irq_in(irq_in), .en_q(en_q), .ie_q(ie_q), .low_q(low_q),
    .irq_out(irq_out), .bank_sel(bank_sel)
  );

  i2c_modectl_dir u_dir (
    .clk(clk), .rst(rst), .en_q(en_q), .wr_en(wr_en),
    .wr_en_bit(wr_data[EN_BIT]), .wr_ms(wr_data[MS_BIT]),
    .wr_tx(wr_data[TX_BIT]), .xfer_busy(xfer_busy),
    .ninth_rise(ninth_rise), .arb_lost(arb_lost),
    .first_frame(first_frame), .rw_bit(rw_bit),
    .ms_q(ms_q), .tx_q(tx_q)
  );

  assign rd_data = {en_q, ie_q, ms_q, tx_q, low_q};
  assign mode    = {ms_q, tx_q};
endmodule

// File: rtl/i2c_modectl_chk.sv
module i2c_modectl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       xfer_busy,
  input logic       ninth_rise,
  input logic       arb_lost,
  input logic       first_frame,
  input logic       rw_bit,
  input logic       irq_in,
  input logic [7:0] rd_data,
  input logic [1:0] mode,
  input logic       irq_out,
  input logic       bank_sel
);
  a_r4_arb_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_data[7] && rd_data[5] && arb_lost) |=> (mode == 2'b00));

  a_r5_first_frame: assert property (@(posedge clk) disable iff (rst)
    (rd_data[7] && mode == 2'b00 && first_frame)
      |=> (mode == {1'b0, $past(rw_bit)}));

  a_r6_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (wr_en && xfer_busy && !ninth_rise && !first_frame && !arb_lost)
      |=> $stable(rd_data[4]));

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (rst)
    (!rd_data[6] || !irq_in) |=> !irq_out);

  a_r10_disabled_events: assert property (@(posedge clk) disable iff (rst)
    (!rd_data[7] && !wr_en && !ninth_rise) |=> $stable(mode));

  a_r9_bank: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (bank_sel == $past(wr_data[7])));
endmodule

bind i2c_modectl i2c_modectl_chk u_chk (.*);

// File: tb/test_i2c_modectl.sv
module test_i2c_modectl;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en, xfer_busy, ninth_rise, arb_lost, first_frame, rw_bit, irq_in;
  logic [7:0] wr_data, rd_data;
  logic [1:0] mode;
  logic       irq_out, bank_sel;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  i2c_modectl i_i2c_modectl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .xfer_busy(xfer_busy), .ninth_rise(ninth_rise), .arb_lost(arb_lost),
    .first_frame(first_frame), .rw_bit(rw_bit), .irq_in(irq_in),
    .rd_data(rd_data), .mode(mode), .irq_out(irq_out), .bank_sel(bank_sel)
  );

  // {wr_en, wr_data, busy, ninth, arb, first, rw, irq_in, exp_rd, exp_irq}
  localparam int NV = 22;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 8'hC0, 6'b000001, 8'hC0, 1'b0}, // R2 R8 ie was 0
    {1'b0, 8'h00, 6'b000001, 8'hC0, 1'b1}, // R8
    {1'b1, 8'hF5, 6'b000000, 8'hF5, 1'b0}, // R2 R3 master transmit
    {1'b0, 8'h00, 6'b001000, 8'hC5, 1'b0}, // R4
    {1'b1, 8'hF0, 6'b100000, 8'hE0, 1'b0}, // R6 pending
    {1'b0, 8'h00, 6'b100000, 8'hE0, 1'b0}, // R6 held
    {1'b0, 8'h00, 6'b110000, 8'hF0, 1'b0}, // R6 applied
    {1'b1, 8'hE0, 6'b100000, 8'hF0, 1'b0}, // R6 pending 0
    {1'b1, 8'hF3, 6'b101000, 8'hC3, 1'b0}, // R4 beats write, cancels
    {1'b0, 8'h00, 6'b110000, 8'hC3, 1'b0}, // R4 nothing pending
    {1'b1, 8'hC0, 6'b000110, 8'hD0, 1'b0}, // R5
    {1'b0, 8'h00, 6'b000100, 8'hD0, 1'b0}, // R11
    {1'b1, 8'hC0, 6'b000000, 8'hC0, 1'b0}, // R2
    {1'b1, 8'hE0, 6'b000110, 8'hD0, 1'b0}, // R5 beats write
    {1'b1, 8'h50, 6'b100000, 8'h50, 1'b0}, // R7 R9
    {1'b1, 8'h70, 6'b000000, 8'h70, 1'b0}, // R3 R9
    {1'b0, 8'h00, 6'b001000, 8'h70, 1'b0}, // R10 arb
    {1'b1, 8'h40, 6'b000000, 8'h40, 1'b0}, // R2
    {1'b0, 8'h00, 6'b000110, 8'h40, 1'b0}, // R10 first frame
    {1'b0, 8'h00, 6'b000001, 8'h40, 1'b1}, // R8
    {1'b1, 8'h0A, 6'b000001, 8'h0A, 1'b1}, // R8 old ie used
    {1'b0, 8'h00, 6'b000001, 8'h0A, 1'b0}  // R8 ie now 0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_data = 0; xfer_busy = 0; ninth_rise = 0;
    arb_lost = 0; first_frame = 0; rw_bit = 0; irq_in = 0;
  endtask

  task automatic wr(input logic [7:0] d, input logic busy);
    idle(); wr_en = 1; wr_data = d; xfer_busy = busy;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 rd_data", rd_data, 0);
    chk("R1 mode", mode, 0);
    chk("R1 irq_out", irq_out, 0);
    chk("R1 bank_sel", bank_sel, 0);

    for (int i = 0; i < NV; i++) begin
      {wr_en, wr_data, xfer_busy, ninth_rise, arb_lost, first_frame, rw_bit, irq_in}
        = VEC[i][23:9];
      @(negedge clk);
      chk($sformatf("table row %0d rd_data", i), rd_data, VEC[i][8:1]);
      chk($sformatf("table row %0d irq_out", i), irq_out, VEC[i][0]);
      chk($sformatf("table row %0d R3 mode", i), mode, VEC[i][6:5]);
      chk($sformatf("table row %0d R9 bank_sel", i), bank_sel, VEC[i][8]);
    end

    // R7: enable cleared by a busy write; a later ninth edge must not load bit 4
    wr(8'hC0, 1'b0);
    wr(8'h50, 1'b1);
    chk("R7 after disabling write", rd_data, 8'h40);
    idle(); xfer_busy = 1; ninth_rise = 1;
    @(negedge clk);
    chk("R7 ninth edge while disabled", rd_data, 8'h40);

    // R6: write with no transfer takes effect on the next edge
    wr(8'h90, 1'b0);
    chk("R6 idle write immediate", rd_data, 8'h90);

    // R1: reset in mid-run
    idle(); irq_in = 1; wr(8'hFF, 1'b0);
    idle(); rst = 1; @(negedge clk); rst = 0;
    chk("R1 mid-run rd_data", rd_data, 0);
    chk("R1 mid-run irq_out", irq_out, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule